// File: doc/BRIEF.md
# Operand Data Capture Nibble Serializer

This trace block watches processor bus references and, for each one that the capture mode selects, sends the operand out on a 4-bit debug data port. A transfer begins with a one-cycle size marker that gives the operand's byte count. The operand data then follows, one nibble per clock, least significant nibble first. A byte takes 2 data nibbles, a word takes 4 and a long takes 8. While a transfer is running the block is busy. A selected reference that arrives then is dropped, and a one-cycle overflow pulse reports the loss.

A disable control freezes the block. The output port and its flags hold their values, the transfer in progress pauses, and new references are ignored. Once the control is released, the transfer resumes from the point where it stopped.

Top module: `opdata_nibbler`

## Requirements
- R1: Capture mode selects the references. cap_mode 2'b00 selects nothing, 2'b01 selects writes only (ref_write=1), 2'b10 selects reads only (ref_write=0) and 2'b11 selects both. A reference is accepted at a clock edge where ref_valid is high, the reference is selected, busy is low and trace_off is low.
- R2: In the cycle after acceptance, nib_valid and busy are 1 and nib_out holds the size marker. The marker is 4'd1 for ref_size 2'b00 (byte), 4'd2 for 2'b01 (word) and 4'd4 for 2'b10 or 2'b11 (long).
- R3: In the cycles after the marker, nib_out carries ref_data one nibble per cycle, starting with ref_data[3:0] and moving up by 4 bits each cycle.
- R4: A byte sends 2 data nibbles, a word 4 and a long 8. busy and nib_valid stay high for exactly one cycle more than the data nibble count and go low together in the next cycle. While idle, nib_out keeps its last value.
- R5: At a clock edge where trace_off is high, nib_out, nib_valid and busy keep their values. A paused transfer resumes where it stopped once trace_off is low again.
- R6: References sampled while trace_off is high are ignored and never raise overflow.
- R7: A selected reference that arrives while busy is high (and trace_off is low) is dropped. overflow is high for the following cycle only, and the transfer in progress continues unchanged.
- R8: After reset, nib_out is 0 and nib_valid, busy and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_mode | input | 2 | Capture mode: 00 none, 01 writes, 10 reads, 11 both |
| ref_valid | input | 1 | A bus reference is present this cycle |
| ref_write | input | 1 | 1 for a write reference, 0 for a read |
| ref_size | input | 2 | Operand size: 00 byte, 01 word, 10 or 11 long |
| ref_data | input | 32 | Operand value of the reference |
| trace_off | input | 1 | Freezes the output port and the transfer |
| nib_out | output | 4 | Marker or data nibble |
| nib_valid | output | 1 | nib_out carries a marker or data nibble |
| busy | output | 1 | A transfer is in progress |
| overflow | output | 1 | One-cycle pulse when a selected reference was dropped |

## Verification
Every cycle, the assertions check four things. An unselected reference never starts a transfer. The first output after acceptance is the correct size marker. A frozen cycle leaves the port unchanged. overflow appears only after a busy cycle and never after a disabled one. The bench alone can show that the data nibbles appear in order and that transfer length is right for each size. It also shows that a dropped reference leaves the running transfer intact and that a paused transfer resumes at the right nibble. It does this by comparing every cycle against a transaction model under directed and random references.

// File: rtl/opdata_nibbler.sv
module opdata_nibbler #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cap_mode,
  input  logic              ref_valid,
  input  logic              ref_write,
  input  logic [1:0]        ref_size,
  input  logic [DATA_W-1:0] ref_data,
  input  logic              trace_off,
  output logic [3:0]        nib_out,
  output logic              nib_valid,
  output logic              busy,
  output logic              overflow
);
  localparam int NIBS  = DATA_W / 4;
  localparam int CNT_W = $clog2(NIBS + 1);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  left;
  logic [3:0]        nib_q;
  logic              busy_q, ovf_q;
  logic [3:0]        marker;
  logic [CNT_W-1:0]  span;

  wire picked = ref_valid && (ref_write ? cap_mode[0] : cap_mode[1]);

  always_comb begin
    case (ref_size)
      2'b00:   begin marker = 4'd1; span = CNT_W'(2);    end
      2'b01:   begin marker = 4'd2; span = CNT_W'(4);    end
      default: begin marker = 4'd4; span = CNT_W'(NIBS); end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      left   <= '0;
      nib_q  <= '0;
      busy_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (trace_off) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= picked && busy_q;
      if (busy_q) begin
        if (left == '0) begin
          busy_q <= 1'b0;
        end else begin
          nib_q <= shreg[3:0];
          shreg <= shreg >> 4;
          left  <= left - CNT_W'(1);
        end
      end else if (picked) begin
        shreg  <= ref_data;
        left   <= span;
        nib_q  <= marker;
        busy_q <= 1'b1;
      end
    end
  end

  assign nib_out   = nib_q;
  assign nib_valid = busy_q;
  assign busy      = busy_q;
  assign overflow  = ovf_q;

  a_r1_unselected_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trace_off && !(ref_valid && (ref_write ? cap_mode[0] : cap_mode[1]))) |=> !busy);

  a_r2_size_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (nib_valid && nib_out == ($past(ref_size) == 2'b00 ? 4'd1 :
                                             $past(ref_size) == 2'b01 ? 4'd2 : 4'd4)));

  a_r5_frozen_port: assert property (@(posedge clk) disable iff (!rst_n)
    trace_off |=> ($stable(nib_out) && $stable(nib_valid) && $stable(busy)));

  a_r6_no_overflow_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    trace_off |=> !overflow);

  a_r7_overflow_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> ($past(busy) && $past(ref_valid)));
endmodule

// File: tb/test_opdata_nibbler.sv
`timescale 1ns/1ps
module test_opdata_nibbler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cap_mode = 2'b00;
  logic        ref_valid = 1'b0, ref_write = 1'b0, trace_off = 1'b0;
  logic [1:0]  ref_size = 2'b00;
  logic [31:0] ref_data = '0;
  logic [3:0]  nib_out;
  logic        nib_valid, busy, overflow;

  int vectors = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R8";

  opdata_nibbler i_opdata_nibbler (
    .clk(clk), .rst_n(rst_n), .cap_mode(cap_mode), .ref_valid(ref_valid),
    .ref_write(ref_write), .ref_size(ref_size), .ref_data(ref_data),
    .trace_off(trace_off), .nib_out(nib_out), .nib_valid(nib_valid),
    .busy(busy), .overflow(overflow));

  always #2 clk = ~clk;

  logic [3:0] m_list [0:8];
  int  m_len = 0, m_idx = 0;
  bit  m_busy = 0, m_ovf = 0;
  logic [3:0] m_nib = '0;

  function automatic int nib_count(logic [1:0] s);
    return (s == 2'b00) ? 2 : (s == 2'b01) ? 4 : 8;
  endfunction

  function automatic logic [3:0] size_mark(logic [1:0] s);
    return (s == 2'b00) ? 4'd1 : (s == 2'b01) ? 4'd2 : 4'd4;
  endfunction

  function automatic bit selected(logic [1:0] m, logic v, logic w);
    return v && (w ? m[0] : m[1]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ovf = 0; m_nib = '0; m_idx = 0; m_len = 0;
    end else if (trace_off) begin
      m_ovf = 0;
    end else begin
      m_ovf = selected(cap_mode, ref_valid, ref_write) && m_busy;
      if (m_busy) begin
        if (m_idx == m_len - 1) m_busy = 0;
        else begin m_idx++; m_nib = m_list[m_idx]; end
      end else if (selected(cap_mode, ref_valid, ref_write)) begin
        m_list[0] = size_mark(ref_size);
        for (int k = 0; k < nib_count(ref_size); k++) m_list[k+1] = ref_data[4*k +: 4];
        m_len = nib_count(ref_size) + 1;
        m_idx = 0; m_busy = 1; m_nib = m_list[0];
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag, "nib_valid", 32'(nib_valid), 32'(m_busy));
      check(tag, "busy", 32'(busy), 32'(m_busy));
      check(tag, "nib_out", 32'(nib_out), 32'(m_nib));
      check(tag, "overflow", 32'(overflow), 32'(m_ovf));
    end
  end

  task automatic drive(bit v, bit w, logic [1:0] s, logic [31:0] d, bit off);
    @(posedge clk); #1;
    ref_valid = v; ref_write = w; ref_size = s; ref_data = d; trace_off = off;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 2'b00, 32'h0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", "reset nib_out", 32'(nib_out), 0);
    check("R8", "reset nib_valid", 32'(nib_valid), 0);
    check("R8", "reset busy", 32'(busy), 0);
    check("R8", "reset overflow", 32'(overflow), 0);
    @(posedge clk); #1; rst_n = 1'b1;

    tag = "R1";
    cap_mode = 2'b00;
    drive(1, 1, 2'b10, 32'hdeadbeef, 0); drive(1, 0, 2'b10, 32'h12345678, 0); idle(3);
    cap_mode = 2'b01;
    drive(1, 0, 2'b01, 32'h0000aaaa, 0); idle(2);
    drive(1, 1, 2'b01, 32'h0000c3a5, 0); idle(7);
    cap_mode = 2'b10;
    drive(1, 1, 2'b00, 32'h000000ff, 0); idle(2);
    drive(1, 0, 2'b00, 32'h0000005a, 0); idle(5);

    tag = "R2";
    cap_mode = 2'b11;
    drive(1, 0, 2'b00, 32'h00000091, 0); idle(4);
    drive(1, 1, 2'b01, 32'h00004e2b, 0); idle(6);
    drive(1, 0, 2'b10, 32'h87654321, 0); idle(10);

    tag = "R3";
    drive(1, 1, 2'b10, 32'h0f1e2d3c, 0); idle(10);
    drive(1, 0, 2'b01, 32'hffff8001, 0); idle(6);

    tag = "R4";
    drive(1, 1, 2'b11, 32'hfedcba98, 0); idle(10);
    drive(1, 1, 2'b00, 32'hffffff7e, 0); idle(1);
    drive(1, 0, 2'b00, 32'h00000011, 0); idle(1);
    drive(1, 0, 2'b00, 32'h00000022, 0); idle(5);

    tag = "R7";
    drive(1, 1, 2'b10, 32'h13579bdf, 0);
    drive(1, 0, 2'b00, 32'h000000ee, 0);
    drive(1, 1, 2'b01, 32'h0000dddd, 0); idle(8);
    drive(1, 0, 2'b00, 32'h00000034, 0); idle(2);
    drive(1, 1, 2'b10, 32'haaaa5555, 0); idle(4);

    tag = "R5";
    drive(1, 0, 2'b10, 32'h2468ace0, 0); idle(2);
    for (int i = 0; i < 4; i++) drive(0, 0, 2'b00, 32'h0, 1);
    idle(10);

    tag = "R6";
    for (int i = 0; i < 3; i++) drive(1, i[0], 2'b10, 32'h99999999, 1);
    idle(2);
    drive(1, 1, 2'b01, 32'h00007777, 0);
    drive(1, 0, 2'b10, 32'h55555555, 1);
    drive(1, 1, 2'b10, 32'h66666666, 1);
    idle(8);

    tag = "R3";
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 50) == 0) cap_mode = 2'($urandom);
      drive(($urandom % 10) < 4, 1'($urandom), 2'($urandom), $urandom,
            ($urandom % 10) == 0);
    end
    idle(12);
    finish_run();
  end
endmodule